// File: doc/BRIEF.md
# Trap-Return Privilege State Unit

This unit carries out the two trap-return operations of a privileged processor core: the return from a supervisor trap handler and the return from a machine trap handler. The core presents one request per cycle, with the current privilege level, the virtualization state, the machine and hypervisor status words, both saved exception PCs, and three configuration flags: compressed instructions enabled, hypervisor support enabled, and memory-protection rules present. One cycle later the unit answers with either a completion or an exception.

On completion the unit supplies the rewritten status words, the privilege level and virtualization state to resume in, and the PC to jump to. When the return re-enters a virtual machine it also raises a one-cycle pulse that asks the surrounding core to exchange its hypervisor and guest register banks; the exchange itself happens outside. On an exception the unit supplies a cause code and echoes the incoming state unchanged, so the core can discard the result without undoing anything.

Top module: `trp_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, `done_o`, `exc_o` and `swap_o` are 0.
- R2: A request with `req_i`=1 yields exactly one of `done_o` or `exc_o` on the next cycle; with no request both stay 0.
- R3: A supervisor return (`kind_i`=0) from user privilege (`priv_i`=0) raises cause 2 (illegal instruction).
- R4: With `c_en_i`=0 and bits [1:0] of the selected return PC non-zero, the return raises cause 0 (misaligned); with `c_en_i`=1 the same PC completes. The privilege check of R3/R9 takes precedence.
- R5: A supervisor return with status bit 22 (trap-return lock) set raises cause 2 when `priv_i` is below 3; from privilege 3 it completes.
- R6: With `h_en_i`=1, `virt_i`=1 and hypervisor-status bit 22 set, a supervisor return that passes R3–R5 raises cause 22 (virtual instruction).
- R7: A completed supervisor return copies status bit 5 into bit 1, sets bit 5, clears bit 8, outputs privilege {0, old bit 8} and PC `sepc_i`.
- R8: A completed supervisor return with `h_en_i`=1 and `virt_i`=0 sets `virt_o` to hypervisor-status bit 7, clears that bit, and pulses `swap_o` if it was 1; otherwise `virt_o` equals `virt_i` and `swap_o` is 0.
- R9: A machine return (`kind_i`=1) with `priv_i` other than 3 raises cause 2.
- R10: A completed machine return copies status bit 7 into bit 3, sets bit 7, clears bits [12:11] and bit 39, outputs privilege equal to old bits [12:11] and PC `mepc_i`.
- R11: A completed machine return with `h_en_i`=1 sets `virt_o` to old status bit 39 and pulses `swap_o` if it was 1; with `h_en_i`=0, `virt_o` equals `virt_i` and `swap_o` is 0.
- R12: A machine return with `prot_en_i`=0 and old bits [12:11] not equal to 3 raises cause 2.
- R13: On an exception, `mstatus_o`, `hstatus_o`, `priv_o` and `virt_o` equal the request's inputs and `swap_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe |
| kind_i | input | 1 | 0 supervisor return, 1 machine return |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| virt_i | input | 1 | Current virtualization state |
| mstatus_i | input | XLEN | Machine status word |
| hstatus_i | input | XLEN | Hypervisor status word |
| sepc_i | input | XLEN | Saved supervisor exception PC |
| mepc_i | input | XLEN | Saved machine exception PC |
| c_en_i | input | 1 | Compressed instructions enabled |
| h_en_i | input | 1 | Hypervisor support enabled |
| prot_en_i | input | 1 | Memory-protection rules present |
| done_o | output | 1 | Return completed (one-cycle pulse) |
| exc_o | output | 1 | Return faulted (one-cycle pulse) |
| cause_o | output | 5 | Exception cause (0, 2 or 22) |
| priv_o | output | 2 | Privilege to resume in |
| virt_o | output | 1 | Virtualization state to resume in |
| mstatus_o | output | XLEN | Updated machine status word |
| hstatus_o | output | XLEN | Updated hypervisor status word |
| pc_o | output | XLEN | Return target PC |
| swap_o | output | 1 | Register bank exchange request (one-cycle pulse) |

## Verification
The assertions assume the input fields are sampled in the same cycle as `req_i` and that `priv_i` carries only the encodings 0, 1 or 3; the reserved value 2 is never driven by the stimulus. They also assume requests are independent, so each directed scenario sets every input afresh before raising `req_i` for a single cycle. The fault-ordering scenarios deliberately set several trap conditions at once to expose which one wins.

// File: rtl/trp_pkg.sv
package trp_pkg;

    typedef enum logic { RET_SUP = 1'b0, RET_MACH = 1'b1 } ret_kind_t;

    localparam logic [1:0] LVL_USER = 2'd0;
    localparam logic [1:0] LVL_SUP  = 2'd1;
    localparam logic [1:0] LVL_MACH = 2'd3;

    typedef enum logic [4:0] {
        CAUSE_MISALIGN = 5'd0,
        CAUSE_ILLEGAL  = 5'd2,
        CAUSE_VIRTUAL  = 5'd22
    } cause_t;

    // Machine status word field positions
    localparam int ST_SIE   = 1;
    localparam int ST_MIE   = 3;
    localparam int ST_SPIE  = 5;
    localparam int ST_MPIE  = 7;
    localparam int ST_SPP   = 8;
    localparam int ST_MPP_L = 11;
    localparam int ST_MPP_H = 12;
    localparam int ST_TSR   = 22;

    // Hypervisor status word field positions
    localparam int HS_SPV  = 7;
    localparam int HS_VTSR = 22;

    typedef struct packed {
        logic       fault;
        cause_t     cause;
    } verdict_t;

    function automatic logic pc_misaligned(input logic [1:0] low_bits, input logic c_en);
        return !c_en && (low_bits != 2'b00);
    endfunction

endpackage

// File: rtl/trp_check.sv
module trp_check
    import trp_pkg::*;
(
    input  ret_kind_t  kind,
    input  logic [1:0] priv,
    input  logic       virt,
    input  logic       tsr,
    input  logic       vtsr,
    input  logic [1:0] mpp,
    input  logic [1:0] pc_low,
    input  logic       c_en,
    input  logic       h_en,
    input  logic       prot_en,
    output verdict_t   verdict
);
    logic misal;
    assign misal = pc_misaligned(pc_low, c_en);

    always_comb begin
        verdict = '{fault: 1'b0, cause: CAUSE_MISALIGN};
        if (kind == RET_SUP) begin
            if (priv < LVL_SUP)
                verdict = '{fault: 1'b1, cause: CAUSE_ILLEGAL};
            else if (misal)
                verdict = '{fault: 1'b1, cause: CAUSE_MISALIGN};
            else if (tsr && priv < LVL_MACH)
                verdict = '{fault: 1'b1, cause: CAUSE_ILLEGAL};
            else if (h_en && virt && vtsr)
                verdict = '{fault: 1'b1, cause: CAUSE_VIRTUAL};
        end else begin
            if (priv != LVL_MACH)
                verdict = '{fault: 1'b1, cause: CAUSE_ILLEGAL};
            else if (misal)
                verdict = '{fault: 1'b1, cause: CAUSE_MISALIGN};
            else if (!prot_en && mpp != LVL_MACH)
                verdict = '{fault: 1'b1, cause: CAUSE_ILLEGAL};
        end
    end
endmodule

// File: rtl/trp_update.sv
module trp_update
    import trp_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int MPV_POS = 39
) (
    input  ret_kind_t       kind,
    input  logic            virt,
    input  logic            h_en,
    input  logic [XLEN-1:0] ms,
    input  logic [XLEN-1:0] hs,
    output logic [XLEN-1:0] ms_n,
    output logic [XLEN-1:0] hs_n,
    output logic [1:0]      priv_n,
    output logic            virt_n,
    output logic            swap_n
);
    always_comb begin
        ms_n   = ms;
        hs_n   = hs;
        virt_n = virt;
        swap_n = 1'b0;
        if (kind == RET_SUP) begin
            ms_n[ST_SIE]  = ms[ST_SPIE];
            ms_n[ST_SPIE] = 1'b1;
            ms_n[ST_SPP]  = 1'b0;
            priv_n        = {1'b0, ms[ST_SPP]};
            if (h_en && !virt) begin
                virt_n       = hs[HS_SPV];
                swap_n       = hs[HS_SPV];
                hs_n[HS_SPV] = 1'b0;
            end
        end else begin
            ms_n[ST_MIE]            = ms[ST_MPIE];
            ms_n[ST_MPIE]           = 1'b1;
            ms_n[ST_MPP_H:ST_MPP_L] = LVL_USER;
            ms_n[MPV_POS]           = 1'b0;
            priv_n                  = ms[ST_MPP_H:ST_MPP_L];
            if (h_en) begin
                virt_n = ms[MPV_POS];
                swap_n = ms[MPV_POS];
            end
        end
    end
endmodule

// File: rtl/trp_unit.sv
module trp_unit
    import trp_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int MPV_POS = 39
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_i,
    input  logic            kind_i,
    input  logic [1:0]      priv_i,
    input  logic            virt_i,
    input  logic [XLEN-1:0] mstatus_i,
    input  logic [XLEN-1:0] hstatus_i,
    input  logic [XLEN-1:0] sepc_i,
    input  logic [XLEN-1:0] mepc_i,
    input  logic            c_en_i,
    input  logic            h_en_i,
    input  logic            prot_en_i,
    output logic            done_o,
    output logic            exc_o,
    output logic [4:0]      cause_o,
    output logic [1:0]      priv_o,
    output logic            virt_o,
    output logic [XLEN-1:0] mstatus_o,
    output logic [XLEN-1:0] hstatus_o,
    output logic [XLEN-1:0] pc_o,
    output logic            swap_o
);
    localparam int PC_LSBS = 2;

    ret_kind_t       kind;
    logic [XLEN-1:0] ret_pc;
    verdict_t        verdict;
    logic [XLEN-1:0] ms_n, hs_n;
    logic [1:0]      priv_n;
    logic            virt_n, swap_n;
    ret_kind_t       kind_q;

    assign kind   = ret_kind_t'(kind_i);
    assign ret_pc = (kind == RET_MACH) ? mepc_i : sepc_i;

    trp_check u_check (
        .kind    (kind),
        .priv    (priv_i),
        .virt    (virt_i),
        .tsr     (mstatus_i[ST_TSR]),
        .vtsr    (hstatus_i[HS_VTSR]),
        .mpp     (mstatus_i[ST_MPP_H:ST_MPP_L]),
        .pc_low  (ret_pc[PC_LSBS-1:0]),
        .c_en    (c_en_i),
        .h_en    (h_en_i),
        .prot_en (prot_en_i),
        .verdict (verdict)
    );

    trp_update #(.XLEN(XLEN), .MPV_POS(MPV_POS)) u_update (
        .kind   (kind),
        .virt   (virt_i),
        .h_en   (h_en_i),
        .ms     (mstatus_i),
        .hs     (hstatus_i),
        .ms_n   (ms_n),
        .hs_n   (hs_n),
        .priv_n (priv_n),
        .virt_n (virt_n),
        .swap_n (swap_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o    <= 1'b0;
            exc_o     <= 1'b0;
            swap_o    <= 1'b0;
            cause_o   <= '0;
            priv_o    <= LVL_MACH;
            virt_o    <= 1'b0;
            mstatus_o <= '0;
            hstatus_o <= '0;
            pc_o      <= '0;
            kind_q    <= RET_SUP;
        end else begin
            done_o <= req_i && !verdict.fault;
            exc_o  <= req_i && verdict.fault;
            swap_o <= req_i && !verdict.fault && swap_n;
            if (req_i) begin
                kind_q  <= kind;
                cause_o <= verdict.fault ? verdict.cause : 5'd0;
                pc_o    <= ret_pc;
                if (verdict.fault) begin
                    priv_o    <= priv_i;
                    virt_o    <= virt_i;
                    mstatus_o <= mstatus_i;
                    hstatus_o <= hstatus_i;
                end else begin
                    priv_o    <= priv_n;
                    virt_o    <= virt_n;
                    mstatus_o <= ms_n;
                    hstatus_o <= hs_n;
                end
            end
        end
    end

    // Outcome is exactly one of completion or fault after a request
    assert_one_outcome_R2: assert property (@(posedge clk) disable iff (rst)
        req_i |=> $onehot({done_o, exc_o}));
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> !done_o && !exc_o && !swap_o);
    assert_user_sret_R3: assert property (@(posedge clk) disable iff (rst)
        req_i && kind == RET_SUP && priv_i == LVL_USER |=> exc_o && cause_o == 5'd2);
    assert_mret_priv_R9: assert property (@(posedge clk) disable iff (rst)
        req_i && kind == RET_MACH && priv_i != LVL_MACH |=> exc_o && cause_o == 5'd2);
    assert_mret_fields_R10: assert property (@(posedge clk) disable iff (rst)
        done_o && kind_q == RET_MACH |-> mstatus_o[ST_MPIE] && mstatus_o[ST_MPP_H:ST_MPP_L] == 2'd0
                                          && !mstatus_o[MPV_POS]);
    assert_sret_fields_R7: assert property (@(posedge clk) disable iff (rst)
        done_o && kind_q == RET_SUP |-> mstatus_o[ST_SPIE] && !mstatus_o[ST_SPP] && priv_o != LVL_MACH);
    assert_no_swap_on_fault_R13: assert property (@(posedge clk) disable iff (rst)
        exc_o |-> !swap_o);
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> !done_o && !exc_o && !swap_o);
endmodule

// File: tb/tb_trp_unit.sv
module tb_trp_unit;
    localparam int XLEN = 64;
    localparam logic [63:0] B_SIE = 64'h2, B_MIE = 64'h8, B_SPIE = 64'h20, B_MPIE = 64'h80;
    localparam logic [63:0] B_SPP = 64'h100, B_TSR = 64'h40_0000, B_MPV = 64'h1 << 39;
    localparam logic [63:0] H_SPV = 64'h80, H_VTSR = 64'h40_0000;

    logic clk = 1'b0, rst = 1'b1;
    logic req_i = 1'b0, kind_i = 1'b0, virt_i = 1'b0;
    logic [1:0] priv_i = 2'd3;
    logic [XLEN-1:0] mstatus_i = '0, hstatus_i = '0, sepc_i = '0, mepc_i = '0;
    logic c_en_i = 1'b1, h_en_i = 1'b0, prot_en_i = 1'b1;
    logic done_o, exc_o, virt_o, swap_o;
    logic [4:0] cause_o;
    logic [1:0] priv_o;
    logic [XLEN-1:0] mstatus_o, hstatus_o, pc_o;

    int n_cmp = 0, n_bad = 0;

    always #2 clk = ~clk;

    trp_unit #(.XLEN(XLEN)) dut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic setup(input logic k, input logic [1:0] p, input logic v,
                         input logic [63:0] ms, input logic [63:0] hs,
                         input logic c, input logic h, input logic pr);
        kind_i = k; priv_i = p; virt_i = v; mstatus_i = ms; hstatus_i = hs;
        c_en_i = c; h_en_i = h; prot_en_i = pr;
        sepc_i = 64'h8000_1000; mepc_i = 64'h8000_2000;
    endtask

    task automatic fire();
        req_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic expect_fault(input string tag, input logic [4:0] cause);
        fire();
        chk({tag, " exc"}, exc_o, 1);
        chk({tag, " done"}, done_o, 0);
        chk({tag, " cause"}, cause_o, cause);
        chk({tag, " R13 ms"}, mstatus_o, mstatus_i);
        chk({tag, " R13 hs"}, hstatus_o, hstatus_i);
        chk({tag, " R13 priv"}, priv_o, priv_i);
        chk({tag, " R13 swap"}, swap_o, 0);
    endtask

    task automatic test_reset();
        chk("R1 done", done_o, 0);
        chk("R1 exc", exc_o, 0);
        chk("R1 swap", swap_o, 0);
    endtask

    task automatic test_idle();
        @(negedge clk);
        chk("R2 idle done", done_o, 0);
        chk("R2 idle exc", exc_o, 0);
    endtask

    task automatic test_sret_basic();
        setup(0, 2'd1, 0, B_SPIE | B_SPP, 0, 1, 0, 1);
        fire();
        chk("R2 R7 done", done_o, 1);
        chk("R7 ms", mstatus_o, B_SIE | B_SPIE);
        chk("R7 priv", priv_o, 1);
        chk("R7 pc", pc_o, 64'h8000_1000);
        chk("R8 virt kept", virt_o, 0);
        // SPIE clear, SPP user: SIE cleared, back to user
        setup(0, 2'd3, 0, B_SIE, 0, 1, 0, 1);
        fire();
        chk("R7 ms2", mstatus_o, B_SPIE);
        chk("R7 priv2", priv_o, 0);
    endtask

    task automatic test_sret_user();
        setup(0, 2'd0, 0, B_SPIE, 0, 1, 0, 1);
        expect_fault("R3 user sret", 5'd2);
    endtask

    task automatic test_misalign();
        setup(0, 2'd1, 0, 0, 0, 0, 0, 1);
        sepc_i = 64'h8000_1002;
        expect_fault("R4 sret misaligned", 5'd0);
        setup(0, 2'd1, 0, 0, 0, 1, 0, 1);
        sepc_i = 64'h8000_1002;
        fire();
        chk("R4 compressed ok", done_o, 1);
        chk("R4 compressed pc", pc_o, 64'h8000_1002);
        setup(0, 2'd0, 0, 0, 0, 0, 0, 1);
        sepc_i = 64'h8000_1001;
        expect_fault("R4 priv wins", 5'd2);
        setup(1, 2'd3, 0, 64'h1800, 0, 0, 0, 1);
        mepc_i = 64'h8000_2001;
        expect_fault("R4 mret misaligned", 5'd0);
    endtask

    task automatic test_tsr();
        setup(0, 2'd1, 0, B_TSR, 0, 1, 0, 1);
        expect_fault("R5 tsr sup", 5'd2);
        setup(0, 2'd3, 0, B_TSR | B_SPP, 0, 1, 0, 1);
        fire();
        chk("R5 tsr mach done", done_o, 1);
        chk("R5 tsr mach priv", priv_o, 1);
    endtask

    task automatic test_vtsr();
        setup(0, 2'd1, 1, 0, H_VTSR, 1, 1, 1);
        expect_fault("R6 vtsr", 5'd22);
        chk("R6 virt held", virt_o, 1);
        setup(0, 2'd1, 1, B_TSR, H_VTSR, 1, 1, 1);
        expect_fault("R6 tsr first", 5'd2);
        setup(0, 2'd1, 1, B_SPP, 0, 1, 1, 1);
        fire();
        chk("R8 virt on stays", virt_o, 1);
        chk("R8 virt on no swap", swap_o, 0);
    endtask

    task automatic test_sret_hyp();
        setup(0, 2'd1, 0, B_SPP, H_SPV | 64'h1, 1, 1, 1);
        fire();
        chk("R8 virt", virt_o, 1);
        chk("R8 swap", swap_o, 1);
        chk("R8 hs", hstatus_o, 64'h1);
        chk("R7 ms hyp", mstatus_o, B_SPIE);
        @(negedge clk);
        chk("R8 swap pulse", swap_o, 0);
        setup(0, 2'd1, 0, 0, 0, 1, 1, 1);
        fire();
        chk("R8 spv0 virt", virt_o, 0);
        chk("R8 spv0 swap", swap_o, 0);
    endtask

    task automatic test_mret();
        setup(1, 2'd1, 0, 64'h1800, 0, 1, 0, 1);
        expect_fault("R9 mret from sup", 5'd2);
        setup(1, 2'd0, 0, 64'h1800, 0, 1, 0, 1);
        expect_fault("R9 mret from user", 5'd2);
        setup(1, 2'd3, 0, B_MIE | 64'h800, 0, 1, 0, 1);
        fire();
        chk("R10 done", done_o, 1);
        chk("R10 ms", mstatus_o, B_MPIE);
        chk("R10 priv", priv_o, 1);
        chk("R10 pc", pc_o, 64'h8000_2000);
    endtask

    task automatic test_prot();
        setup(1, 2'd3, 0, B_MPIE, 0, 1, 0, 0);
        expect_fault("R12 no prot user", 5'd2);
        setup(1, 2'd3, 0, 64'h1800, 0, 1, 0, 0);
        fire();
        chk("R12 no prot mach", done_o, 1);
        chk("R12 priv", priv_o, 3);
        chk("R10 ms mach", mstatus_o, B_MPIE);
    endtask

    task automatic test_mret_hyp();
        setup(1, 2'd3, 0, B_MPV | B_MPIE | 64'h800, 0, 1, 1, 1);
        fire();
        chk("R11 virt", virt_o, 1);
        chk("R11 swap", swap_o, 1);
        chk("R10 R11 ms", mstatus_o, B_MIE | B_MPIE);
        setup(1, 2'd3, 1, B_MPV | 64'h800, 0, 1, 0, 1);
        fire();
        chk("R11 no hyp virt", virt_o, 1);
        chk("R11 no hyp swap", swap_o, 0);
        chk("R10 mpv cleared", mstatus_o, B_MPIE);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        test_reset();
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_idle();
        test_sret_basic();
        test_sret_user();
        test_misalign();
        test_tsr();
        test_vtsr();
        test_sret_hyp();
        test_mret();
        test_prot();
        test_mret_hyp();
        test_idle();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule